// File: doc/BRIEF.md
# Divider Tap, Square-Wave and Interrupt Unit

This block counts a 32.768 kHz clock-enable pulse in a binary ripple-free divider. The divider's full wrap gives a one-cycle tick once per second, and that tick drives the calendar's update step. A 4-bit rate code selects one counter stage. The selected stage drives two things: the square-wave pin, and the source of the periodic event. An oscillator-mode code and two enables can bypass the selected stage so that the square-wave pin follows the raw 32 kHz pulse instead.

The unit also keeps three event flags: periodic, alarm and update-done. Each flag has its own mask bit. Together they form an active-low interrupt request, which is modelled as a level plus a pull-down enable for an external open-drain pad. A status read returns the flags and an interrupt summary bit. The same read clears the flags. An event that lands in the read cycle is kept for the next read.

Top module: `sqw_irq_unit`

## Requirements
- R1: While `rst_n` is low the divider is zero, all flags are zero, `irq_n` is 1, `irq_drive` is 0 and `sqw_out` is 0.
- R2: `sec_tick` is high for exactly one cycle for every 32768 cycles with `osc_tick` high. The first pulse comes in the cycle of the 32768th tick after reset.
- R3: Rate code 0 holds `sqw_out` low outside the fast mode and never sets the periodic flag.
- R4: Rate codes 3 to 15 give 8192 Hz down to 2 Hz, halving per step. For code c the output is low for the first 2^(c-2) ticks after reset, then high for the next 2^(c-2) ticks.
- R5: Rate code 1 gives 256 Hz (half period 64 ticks) and code 2 gives 128 Hz (half period 128 ticks).
- R6: With `sqw_en` at 0, `sqw_out` is 0 whatever the other inputs are.
- R7: When `osc_mode` is 3'b011, `sqw_en` is 1 and `fast_en` is 1, `sqw_out` equals `osc_tick` in the same cycle. If any one of the three conditions is dropped, the output returns to the selected stage.
- R8: Each high-to-low transition of the selected stage sets the periodic flag. For code c this happens first after 2^(c-1) ticks. `alarm_evt` sets the alarm flag and `update_evt` sets the update flag. Flags are set whatever their mask bits are.
- R9: `irq_n` is 0 and `irq_drive` is 1 in every cycle where some flag and its mask bit are both 1. Otherwise `irq_n` is 1 and `irq_drive` is 0.
- R10: `stat_data` is {summary, periodic, alarm, update} from bit 3 down to bit 0. The summary bit equals the R9 request. A cycle with `stat_rd` high clears all three flags at the next edge.
- R11: A flag event in the same cycle as `stat_rd` leaves that flag set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | 32.768 kHz clock-enable pulse |
| rate_sel | input | 4 | Divider stage select code |
| osc_mode | input | 3 | Oscillator mode code; 3'b011 allows the fast bypass |
| sqw_en | input | 1 | Square-wave output enable |
| fast_en | input | 1 | 32 kHz bypass enable |
| per_mask | input | 1 | Periodic flag interrupt mask |
| alm_mask | input | 1 | Alarm flag interrupt mask |
| upd_mask | input | 1 | Update flag interrupt mask |
| alarm_evt | input | 1 | Alarm match event pulse |
| update_evt | input | 1 | Update-complete event pulse |
| stat_rd | input | 1 | Status read strobe, clears flags |
| sec_tick | output | 1 | One-cycle pulse once per second |
| sqw_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_drive | output | 1 | Pad pull-down enable for open-drain request |
| stat_data | output | 4 | Status value {summary, periodic, alarm, update} |

## Verification
`sqw_out` and `sec_tick` are decoded combinationally from the divider register, so their value after a given number of counted ticks can be read at the falling edge after that rising edge. The bench therefore counts edges exactly: for a half period of 2^b ticks it checks the level after 2^b-1 edges and again after 2^b edges. Flags are registered, so an event applied before an edge shows in `stat_data` at the next falling edge. The request level, the summary bit and the status value during a read are combinational on the flags, so they are checked in the cycle the masks or `stat_rd` are applied. The clearing result is checked one edge later.

// File: rtl/sqw_irq_pkg.sv
`timescale 1ns/1ps
package sqw_irq_pkg;

   // Event flag set, packed so that bit 2 = periodic, 1 = alarm, 0 = update.
   typedef struct packed {
      logic periodic;
      logic alarm;
      logic update;
   } evt_flags_t;

   // Maps a rate code to a divider stage index. Code 0 is the "off" code
   // and returns 0; the caller gates the stage with a separate enable.
   function automatic int tap_index(input int code, input int offs,
                                    input int alias_a, input int alias_b);
      if (code == 0)      return 0;
      else if (code == 1) return alias_a;
      else if (code == 2) return alias_b;
      else                return code - offs;
   endfunction

endpackage

// File: rtl/sqw_div_chain.sv
`timescale 1ns/1ps
module sqw_div_chain #(
   parameter int DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   output logic [DIV_W-1:0] cnt_o,
   output logic [DIV_W-1:0] carry_o,
   output logic             sec_tick_o
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] carry;

   initial begin : p_param_chk
      assert (DIV_W >= 2 && DIV_W <= 24)
         else $error("sqw_div_chain: DIV_W out of range");
   end

   // carry[k] is high when stages 0..k are all ones: stage k+1 toggles next tick
   always_comb begin
      carry[0] = cnt_q[0];
      for (int k = 1; k < DIV_W; k++) begin
         carry[k] = carry[k-1] & cnt_q[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (osc_tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o      = cnt_q;
   assign carry_o    = carry;
   assign sec_tick_o = osc_tick & carry[DIV_W-1];

   // R2: a second tick is the wrap point of the divider
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick_o |=> (cnt_q == '0));

   // R2: without a tick the divider holds
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(cnt_q));

endmodule

// File: rtl/sqw_tap_sel.sv
`timescale 1ns/1ps
module sqw_tap_sel #(
   parameter int DIV_W       = 15,
   parameter int RATE_W      = 4,
   parameter int OSC_W       = 3,
   parameter int FAST_CODE   = 3,
   parameter int TAP_OFFSET  = 2,
   parameter int ALIAS_A_BIT = 6,
   parameter int ALIAS_B_BIT = 7,
   parameter bit FAST_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic [DIV_W-1:0]  cnt_i,
   input  logic [DIV_W-1:0]  carry_i,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic [OSC_W-1:0]  osc_mode,
   input  logic              sqw_en,
   input  logic              fast_en,
   output logic              sqw_o,
   output logic              tap_evt_o
);
   import sqw_irq_pkg::*;

   localparam int IDX_W    = $clog2(DIV_W);
   localparam int MAX_CODE = (1 << RATE_W) - 1;
   localparam int MAX_IDX  = MAX_CODE - TAP_OFFSET;

   initial begin : p_param_chk
      assert (MAX_IDX < DIV_W && MAX_IDX >= 0)
         else $error("sqw_tap_sel: top rate code selects beyond divider");
      assert (ALIAS_A_BIT < DIV_W && ALIAS_B_BIT < DIV_W)
         else $error("sqw_tap_sel: alias stage beyond divider");
      assert (FAST_CODE < (1 << OSC_W))
         else $error("sqw_tap_sel: fast code does not fit mode field");
   end

   logic [IDX_W-1:0] tap_idx;
   logic             rate_on;
   logic             tap_lvl;
   logic             fast_sel;

   assign tap_idx   = IDX_W'(tap_index(int'(rate_sel), TAP_OFFSET,
                                       ALIAS_A_BIT, ALIAS_B_BIT));
   assign rate_on   = (rate_sel != '0);
   assign tap_lvl   = rate_on & cnt_i[tap_idx];
   assign tap_evt_o = rate_on & osc_tick & carry_i[tap_idx];

   generate
      if (FAST_BYPASS) begin : g_fast
         assign fast_sel = fast_en & (osc_mode == OSC_W'(FAST_CODE));
      end else begin : g_plain
         assign fast_sel = 1'b0;
      end
   endgenerate

   assign sqw_o = sqw_en & (fast_sel ? osc_tick : tap_lvl);

   // R6: disabled output stays low
   a_r6_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      !sqw_en |-> !sqw_o);

   // R3: off code produces no periodic event
   a_r3_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |-> !tap_evt_o);

   // R8: a periodic event always moves the divider
   a_r8_evt_moves: assert property (@(posedge clk) disable iff (!rst_n)
      tap_evt_o |=> (cnt_i != $past(cnt_i)));

endmodule

// File: rtl/sqw_flag_bank.sv
`timescale 1ns/1ps
module sqw_flag_bank #(
   parameter int NUM_FLAGS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic [NUM_FLAGS-1:0] mask_i,
   input  logic                 rd_i,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 irq_o
);

   initial begin : p_param_chk
      assert (NUM_FLAGS >= 1 && NUM_FLAGS <= 16)
         else $error("sqw_flag_bank: NUM_FLAGS out of range");
   end

   logic [NUM_FLAGS-1:0] flag_q;

   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q[g] <= 1'b0;
            end else begin
               // a read clears, but a fresh event in the same cycle wins
               flag_q[g] <= (flag_q[g] & ~rd_i) | set_i[g];
            end
         end

         // R11: an event is never lost
         a_r11_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);

         // R10: a read without a new event leaves the flag clear
         a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !set_i[g]) |=> !flag_q[g]);
      end
   endgenerate

   assign flags_o = flag_q;
   assign irq_o   = |(flag_q & mask_i);

   // R9: no request with every mask off
   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i == '0) |-> !irq_o);

   // R10: request drops after a read that brings no event
   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && set_i == '0) |=> !irq_o);

endmodule

// File: rtl/sqw_irq_unit.sv
`timescale 1ns/1ps
module sqw_irq_unit #(
   parameter int DIV_W       = 15,
   parameter int RATE_W      = 4,
   parameter int OSC_W       = 3,
   parameter int FAST_CODE   = 3,
   parameter int TAP_OFFSET  = 2,
   parameter int ALIAS_A_BIT = 6,
   parameter int ALIAS_B_BIT = 7,
   parameter bit FAST_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic [OSC_W-1:0]  osc_mode,
   input  logic              sqw_en,
   input  logic              fast_en,
   input  logic              per_mask,
   input  logic              alm_mask,
   input  logic              upd_mask,
   input  logic              alarm_evt,
   input  logic              update_evt,
   input  logic              stat_rd,
   output logic              sec_tick,
   output logic              sqw_out,
   output logic              irq_n,
   output logic              irq_drive,
   output logic [3:0]        stat_data
);
   import sqw_irq_pkg::*;

   localparam int NUM_FLAGS = $bits(evt_flags_t);

   initial begin : p_param_chk
      assert (NUM_FLAGS + 1 == 4)
         else $error("sqw_irq_unit: status width mismatch");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] carry;
   logic             tap_evt;
   logic             irq;
   evt_flags_t       set_s;
   evt_flags_t       mask_s;
   evt_flags_t       flags_s;

   sqw_div_chain #(.DIV_W(DIV_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick   (osc_tick),
      .cnt_o      (cnt),
      .carry_o    (carry),
      .sec_tick_o (sec_tick)
   );

   sqw_tap_sel #(
      .DIV_W       (DIV_W),
      .RATE_W      (RATE_W),
      .OSC_W       (OSC_W),
      .FAST_CODE   (FAST_CODE),
      .TAP_OFFSET  (TAP_OFFSET),
      .ALIAS_A_BIT (ALIAS_A_BIT),
      .ALIAS_B_BIT (ALIAS_B_BIT),
      .FAST_BYPASS (FAST_BYPASS)
   ) u_tap (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_tick  (osc_tick),
      .cnt_i     (cnt),
      .carry_i   (carry),
      .rate_sel  (rate_sel),
      .osc_mode  (osc_mode),
      .sqw_en    (sqw_en),
      .fast_en   (fast_en),
      .sqw_o     (sqw_out),
      .tap_evt_o (tap_evt)
   );

   assign set_s  = '{periodic: tap_evt,  alarm: alarm_evt, update: update_evt};
   assign mask_s = '{periodic: per_mask, alarm: alm_mask,  update: upd_mask};

   sqw_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_s),
      .mask_i  (mask_s),
      .rd_i    (stat_rd),
      .flags_o (flags_s),
      .irq_o   (irq)
   );

   assign irq_n     = ~irq;
   assign irq_drive = irq;
   assign stat_data = {irq, flags_s};

   // R9: pad drive and level always agree
   a_r9_pad_agree: assert property (@(posedge clk) disable iff (!rst_n)
      irq_drive != irq_n);

endmodule

// File: tb/tb_sqw_irq_unit.sv
`timescale 1ns/1ps
module tb_sqw_irq_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic [3:0] rate_sel = '0;
   logic [2:0] osc_mode = '0;
   logic       sqw_en = 1'b0, fast_en = 1'b0;
   logic       per_mask = 1'b0, alm_mask = 1'b0, upd_mask = 1'b0;
   logic       alarm_evt = 1'b0, update_evt = 1'b0, stat_rd = 1'b0;
   logic       sec_tick, sqw_out, irq_n, irq_drive;
   logic [3:0] stat_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sqw_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rate_sel(rate_sel),
      .osc_mode(osc_mode), .sqw_en(sqw_en), .fast_en(fast_en),
      .per_mask(per_mask), .alm_mask(alm_mask), .upd_mask(upd_mask),
      .alarm_evt(alarm_evt), .update_evt(update_evt), .stat_rd(stat_rd),
      .sec_tick(sec_tick), .sqw_out(sqw_out), .irq_n(irq_n),
      .irq_drive(irq_drive), .stat_data(stat_data)
   );

   // {rate code, log2 of half period in ticks}
   localparam logic [7:0] RVEC [0:14] = '{
      8'h16, 8'h27, 8'h31, 8'h42, 8'h53, 8'h64, 8'h75, 8'h86,
      8'h97, 8'hA8, 8'hB9, 8'hCA, 8'hDB, 8'hEC, 8'hFD
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; osc_tick = 1'b0; stat_rd = 1'b0;
      alarm_evt = 1'b0; update_evt = 1'b0;
      wait_n(2);
      rst_n = 1'b1;
   endtask

   initial begin
      #900000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state, observed while reset is held
      @(negedge clk);
      sqw_en = 1'b1; rate_sel = 4'd3;
      per_mask = 1'b1; alm_mask = 1'b1; upd_mask = 1'b1;
      osc_tick = 1'b1;
      wait_n(1);
      chk("R1 sqw", sqw_out, 0);
      chk("R1 irq_n", irq_n, 1);
      chk("R1 irq_drive", irq_drive, 0);
      chk("R1 stat", stat_data, 0);
      osc_tick = 1'b0;

      // R4 / R5 / R8: table of rate codes
      for (int i = 0; i < 15; i++) begin
         int b;
         b = int'(RVEC[i][3:0]);
         do_reset();
         rate_sel = RVEC[i][7:4];
         sqw_en = 1'b1; osc_mode = 3'd0; fast_en = 1'b0;
         osc_tick = 1'b1;
         wait_n((1 << b) - 1);
         chk("R4/R5 sqw low half", sqw_out, 0);
         wait_n(1);
         chk("R4/R5 sqw high half", sqw_out, 1);
         wait_n((1 << b) - 1);
         chk("R8 periodic not yet", stat_data[2], 0);
         wait_n(1);
         chk("R8 periodic set", stat_data[2], 1);
         chk("R4/R5 sqw back low", sqw_out, 0);
         osc_tick = 1'b0;
      end

      // R3: code 0 keeps output low and sets no periodic flag
      do_reset();
      rate_sel = 4'd0; sqw_en = 1'b1; osc_tick = 1'b1;
      for (int k = 0; k < 8; k++) begin
         wait_n(16);
         chk("R3 sqw low", sqw_out, 0);
      end
      chk("R3 no periodic", stat_data[2], 0);
      osc_tick = 1'b0;

      // R6: enable off hides a high stage
      do_reset();
      rate_sel = 4'd3; sqw_en = 1'b0; osc_tick = 1'b1;
      wait_n(2);
      osc_tick = 1'b0;
      wait_n(1);
      chk("R6 disabled low", sqw_out, 0);
      sqw_en = 1'b1;
      wait_n(1);
      chk("R6 enabled high", sqw_out, 1);

      // R7: fast bypass follows the tick
      rate_sel = 4'd0; osc_mode = 3'b011; fast_en = 1'b1; sqw_en = 1'b1;
      osc_tick = 1'b0;
      wait_n(1);
      chk("R7 fast low", sqw_out, 0);
      osc_tick = 1'b1;
      wait_n(1);
      chk("R7 fast high", sqw_out, 1);
      fast_en = 1'b0;
      wait_n(1);
      chk("R7 no fast_en", sqw_out, 0);
      fast_en = 1'b1; osc_mode = 3'b010;
      wait_n(1);
      chk("R7 wrong mode", sqw_out, 0);
      osc_mode = 3'b011; sqw_en = 1'b0;
      wait_n(1);
      chk("R7 no sqw_en", sqw_out, 0);
      osc_tick = 1'b0; fast_en = 1'b0; osc_mode = 3'd0;

      // R2: one-second tick
      do_reset();
      rate_sel = 4'd0; osc_tick = 1'b1;
      wait_n(32766);
      chk("R2 before wrap", sec_tick, 0);
      wait_n(1);
      chk("R2 at wrap", sec_tick, 1);
      wait_n(1);
      chk("R2 after wrap", sec_tick, 0);
      osc_tick = 1'b0;

      // R8 / R9 / R10: alarm and update flags, masks, read
      do_reset();
      rate_sel = 4'd0; per_mask = 1'b0; alm_mask = 1'b0; upd_mask = 1'b0;
      alarm_evt = 1'b1;
      wait_n(1);
      alarm_evt = 1'b0;
      chk("R8 alarm flag", stat_data, 4'b0010);
      chk("R9 masked irq_n", irq_n, 1);
      alm_mask = 1'b1;
      wait_n(1);
      chk("R9 unmasked irq_n", irq_n, 0);
      chk("R9 irq_drive", irq_drive, 1);
      update_evt = 1'b1;
      wait_n(1);
      update_evt = 1'b0;
      chk("R8 update flag", stat_data, 4'b1011);
      stat_rd = 1'b1;
      #0.5;
      chk("R10 read value", stat_data, 4'b1011);
      wait_n(1);
      stat_rd = 1'b0;
      chk("R10 cleared", stat_data, 4'b0000);
      chk("R10 released", irq_n, 1);

      // R11: event in the read cycle survives
      alarm_evt = 1'b1;
      wait_n(1);
      alarm_evt = 1'b0;
      stat_rd = 1'b1; update_evt = 1'b1;
      wait_n(1);
      stat_rd = 1'b0; update_evt = 1'b0;
      chk("R11 kept update only", stat_data, 4'b0001);
      upd_mask = 1'b1;
      wait_n(1);
      chk("R11 request from kept flag", irq_n, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule